// File: doc/BRIEF.md
# ADC Clock Divider, Auto-Trigger and Result Alignment Control

This block is the control slice that sits beside a successive-approximation converter. It holds one 8-bit control byte that is written and read over a plain register port. From that byte it takes a division code that sets how often a one-cycle clock-enable pulse goes to the converter, and an alignment flag that decides where a 10-bit conversion result lands inside a 16-bit data word.

It also starts conversions automatically. A separate 3-bit selector picks one of eight trigger flags. When the external auto-trigger enable is high, a rising edge seen on the selected flag produces a single-cycle start pulse. The previously selected value is what gets compared against, so moving the selector from a low flag to a high flag also counts as a rising edge. The converter core, its sequencer, interrupt handling and the register that holds the auto-trigger enable are outside this block.

Top module: `adc_ctl_slice`

## Requirements
- R1: While reset is high and in the first cycle after it, the control byte reads 0x00 and both the clock-enable and the start pulse are low.
- R2: A write stores data bits 7, 6, 3 and 2:0; the stored byte is visible on the read port from the cycle after the write, and read bits 5:4 are always 0.
- R3: Control bits 2:0 choose the divisor: codes 0 and 1 give 2, code 2 gives 4, 3 gives 8, 4 gives 16, 5 gives 32, 6 gives 64, 7 gives 128.
- R4: The clock-enable output is a one-cycle pulse repeating every divisor cycles; the first pulse comes divisor clock edges after reset or after a restart.
- R5: A write whose bits 2:0 differ from the stored code restarts the divider at that edge; a write with an equal code leaves the pulse cadence untouched.
- R6: With control bit 3 at 0 the data word holds the result in bits 9:0 and zeros in bits 15:10.
- R7: With control bit 3 at 1 the data word holds the result in bits 15:6 and zeros in bits 5:0.
- R8: The data word follows the result input and the alignment bit without waiting for any conversion; a new alignment shows in the cycle after its write.
- R9: With auto-trigger enabled, the start output goes high for exactly one cycle after the clock edge at which the selected flag is first sampled high following a low sample.
- R10: While the auto-trigger enable is low, no start pulse is produced whatever the flags do.
- R11: Changing the selector from a flag sampled low to a flag sampled high counts as a rising edge and produces a start pulse.
- R12: Flags that are not selected have no effect on the start output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| rd_data | output | 8 | Control byte read value |
| trig_sel | input | 3 | Trigger flag selector |
| auto_trig_en | input | 1 | Auto-trigger enable |
| trig_flags | input | 8 | Candidate trigger flags |
| result_in | input | 10 | Raw conversion result |
| conv_start | output | 1 | One-cycle conversion start pulse |
| adc_clk_en | output | 1 | Converter clock-enable pulse |
| data_word | output | 16 | Aligned result word |

## Verification
The read byte, clock-enable and start pulse are all registered, so each is due one clock edge after the inputs that cause it and the bench samples them shortly after that edge. The data word is combinational from the result input and the stored alignment bit, so it is compared in the same cycle a new result is driven and one edge after an alignment write. A bench model, stepped once per edge with the inputs that were present before the edge, tracks the stored byte, the cycles since the last divider restart and the last selected flag value, and every output is compared against it after every edge across directed corner cases and a seeded random run.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic [1:0]        spare_hi;
    logic              align_left;
    logic [CODE_W-1:0] div_code;
  } ctrl_t;

  function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
    return {c.spare_hi, 2'b00, c.align_left, c.div_code};
  endfunction

  function automatic ctrl_t byte_to_ctrl(input logic [7:0] b);
    ctrl_t c;
    c.spare_hi   = b[7:6];
    c.align_left = b[3];
    c.div_code   = b[2:0];
    return c;
  endfunction
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic              restart,
  output logic              clk_en
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  int               shamt;

  always_comb begin
    shamt = (code == '0) ? 1 : int'(code);
    lim   = {CNT_W{1'b1}} >> (CNT_W - shamt);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q  <= '0;
      clk_en <= 1'b0;
    end else begin
      clk_en <= (cnt_q == lim);
      cnt_q  <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end
  end

  assert_en_single_R4: assert property (@(posedge clk) disable iff (rst)
    clk_en |=> !clk_en);
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim);
  assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0 && !clk_en));
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int NSRC  = 8,
  parameter int SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             enable,
  input  logic [NSRC-1:0]  flags,
  output logic             start
);
  logic sel_val;
  logic prev_q;

  assign sel_val = flags[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      start  <= 1'b0;
    end else begin
      prev_q <= sel_val;
      start  <= enable & sel_val & ~prev_q;
    end
  end

  assert_start_single_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
  assert_gate_off_R10: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !start);
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int RES_W  = 10,
  parameter int WORD_W = 16
) (
  input  logic              align_left,
  input  logic [RES_W-1:0]  result,
  output logic [WORD_W-1:0] word
);
  localparam int PAD_W = WORD_W - RES_W;

  always_comb begin
    if (align_left) word = {result, {PAD_W{1'b0}}};
    else            word = {{PAD_W{1'b0}}, result};
  end
endmodule

// File: rtl/adc_ctl_slice.sv
module adc_ctl_slice #(
  parameter int RES_W  = 10,
  parameter int WORD_W = 16,
  parameter int NSRC   = 8,
  parameter int SEL_W  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic              auto_trig_en,
  input  logic [NSRC-1:0]   trig_flags,
  input  logic [RES_W-1:0]  result_in,
  output logic              conv_start,
  output logic              adc_clk_en,
  output logic [WORD_W-1:0] data_word
);
  import adc_ctl_pkg::*;

  ctrl_t ctrl_q;
  ctrl_t ctrl_new;
  logic  div_restart;

  assign ctrl_new    = byte_to_ctrl(wr_data);
  assign div_restart = wr_en && (ctrl_new.div_code != ctrl_q.div_code);

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_new;
  end

  assign rd_data = ctrl_to_byte(ctrl_q);

  adc_prescaler #(.CODE_W(CODE_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .code    (ctrl_q.div_code),
    .restart (div_restart),
    .clk_en  (adc_clk_en)
  );

  adc_trig_edge #(.NSRC(NSRC), .SEL_W(SEL_W)) u_trig (
    .clk    (clk),
    .rst    (rst),
    .sel    (trig_sel),
    .enable (auto_trig_en),
    .flags  (trig_flags),
    .start  (conv_start)
  );

  adc_result_fmt #(.RES_W(RES_W), .WORD_W(WORD_W)) u_fmt (
    .align_left (ctrl_q.align_left),
    .result     (result_in),
    .word       (data_word)
  );

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rd_data[5:4] == 2'b00);
  assert_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == ($past(wr_data) & 8'hCF));
  assert_right_pad_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_data[3] |-> data_word[WORD_W-1:RES_W] == '0);
  assert_left_pad_R7: assert property (@(posedge clk) disable iff (rst)
    rd_data[3] |-> data_word[WORD_W-RES_W-1:0] == '0);
endmodule

// File: tb/tb_adc_ctl_slice.sv
`timescale 1ns/1ps
module tb_adc_ctl_slice;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [2:0] trig_sel = '0;
  logic       auto_trig_en = 1'b0;
  logic [7:0] trig_flags = '0;
  logic [9:0] result_in = '0;
  logic       conv_start, adc_clk_en;
  logic [15:0] data_word;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_reg = '0;
  int         m_t = 0;
  logic       m_prev = 1'b0;
  string      tag_trig = "R9";
  string      tag_div  = "R4";

  always #2 clk = ~clk;

  adc_ctl_slice dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .trig_sel(trig_sel), .auto_trig_en(auto_trig_en), .trig_flags(trig_flags),
    .result_in(result_in), .conv_start(conv_start), .adc_clk_en(adc_clk_en),
    .data_word(data_word)
  );

  function automatic int divisor(input logic [2:0] c);
    return (c == 3'd0) ? 2 : (1 << c);
  endfunction

  function automatic logic [15:0] fmt(input logic left, input logic [9:0] r);
    return left ? {r, 6'b0} : {6'b0, r};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(input logic we, input logic [7:0] wd, input logic [2:0] ts,
                       input logic ate, input logic [7:0] fl, input logic [9:0] res);
    logic sel_now;
    logic exp_start;
    wr_en = we; wr_data = wd; trig_sel = ts; auto_trig_en = ate;
    trig_flags = fl; result_in = res;
    #1;
    check("R8", {16'h0, data_word}, {16'h0, fmt(m_reg[3], res)});
    sel_now   = fl[ts];
    exp_start = ate & sel_now & ~m_prev;
    m_prev    = sel_now;
    if (we && wd[2:0] != m_reg[2:0]) m_t = 0; else m_t++;
    if (we) m_reg = wd & 8'hCF;
    @(posedge clk); #1;
    check("R2", {24'h0, rd_data}, {24'h0, m_reg});
    check(tag_div, {31'h0, adc_clk_en},
          {31'h0, (m_t != 0 && (m_t % divisor(m_reg[2:0])) == 0)});
    check(tag_trig, {31'h0, conv_start}, {31'h0, exp_start});
    check(m_reg[3] ? "R7" : "R6", {16'h0, data_word}, {16'h0, fmt(m_reg[3], res)});
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0A1C);
    trig_flags = 8'hFF; auto_trig_en = 1'b1;
    repeat (3) begin
      @(posedge clk); #1;
      check("R1", {24'h0, rd_data}, 32'h0);
      check("R1", {31'h0, adc_clk_en}, 32'h0);
      check("R1", {31'h0, conv_start}, 32'h0);
    end
    rst = 1'b0;
    m_prev = 1'b0;
    // R1: first cycle out of reset with everything low
    cycle(0, 0, 0, 0, 8'h00, 10'h000);
    check("R1", {24'h0, rd_data}, 32'h0);

    // R3: code 0 and code 1 both divide by two
    tag_div = "R3";
    repeat (8) cycle(0, 0, 0, 0, 0, 10'h155);
    cycle(1, 8'h01, 0, 0, 0, 10'h155);
    repeat (8) cycle(0, 0, 0, 0, 0, 10'h155);
    // R2: write all ones, reserved mid bits read zero
    cycle(1, 8'hFF, 0, 0, 0, 10'h3FF);
    repeat (130) cycle(0, 0, 0, 0, 0, 10'h3FF);
    // R5: same code rewrite keeps cadence, different code restarts
    tag_div = "R5";
    cycle(1, 8'h02, 0, 0, 0, 10'h2AA);
    repeat (3) cycle(0, 0, 0, 0, 0, 10'h2AA);
    cycle(1, 8'h02, 0, 0, 0, 10'h2AA);
    repeat (6) cycle(0, 0, 0, 0, 0, 10'h2AA);
    cycle(1, 8'h03, 0, 0, 0, 10'h2AA);
    repeat (17) cycle(0, 0, 0, 0, 0, 10'h2AA);
    tag_div = "R4";

    // R8: alignment flips while result is held
    cycle(1, 8'h0B, 0, 0, 0, 10'h3C1);
    cycle(1, 8'h03, 0, 0, 0, 10'h3C1);
    cycle(0, 0, 0, 0, 0, 10'h001);

    // R9: rising edge of selected flag with enable high
    cycle(0, 0, 3'd5, 1, 8'h00, 0);
    cycle(0, 0, 3'd5, 1, 8'h20, 0);
    cycle(0, 0, 3'd5, 1, 8'h20, 0);
    // R10: edge while enable is low gives nothing
    tag_trig = "R10";
    cycle(0, 0, 3'd5, 0, 8'h00, 0);
    cycle(0, 0, 3'd5, 0, 8'h20, 0);
    cycle(0, 0, 3'd5, 1, 8'h20, 0);
    // R11: selection moves from low source to high source
    tag_trig = "R11";
    cycle(0, 0, 3'd0, 1, 8'h04, 0);
    cycle(0, 0, 3'd2, 1, 8'h04, 0);
    cycle(0, 0, 3'd0, 1, 8'h04, 0);
    // R12: other flags toggle, selected one stays low
    tag_trig = "R12";
    cycle(0, 0, 3'd7, 1, 8'h00, 0);
    cycle(0, 0, 3'd7, 1, 8'h7F, 0);
    cycle(0, 0, 3'd7, 1, 8'h00, 0);
    cycle(0, 0, 3'd7, 1, 8'h55, 0);
    tag_trig = "R9";

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cycle((r[3:0] == 4'd0), r[11:4], r[14:12], r[15] | r[16],
            (r[17] ? r[25:18] : 8'h00), $urandom);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule